// File: doc/BRIEF.md
# Display raster timing generator

This block turns a pixel clock into the raster of a display frame. A horizontal counter steps through each line and a vertical counter steps through the lines. The block decodes both into an active-video flag, horizontal and vertical sync pulses, and a field flag for interlaced formats. The line length, the active width and height, the sync position and length, and each sync polarity are set by configuration inputs, so one instance can cover standard-definition, high-definition and panel timings.

The block has two modes. In master mode it runs freely and announces each frame start on a frame-sync pin that it drives. In slave mode that pin is an input. A rising edge on it restarts both counters together, so the line phase also comes from the frame sync. Only one such edge per frame of the block's own count is accepted. This means an external per-field vertical sync cannot pull the raster around.

Top module: `raster_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `h_count`, `v_count` and `field` become 0.
- R2: `h_count` counts 0, 1, … up to `cfg_h_total`-1 and then returns to 0. `v_count` advances by one each time `h_count` returns to 0.
- R3: With `cfg_interlace`=0, a frame has `cfg_v_total` lines, `v_count` returns to 0 after line `cfg_v_total`-1, and `field` stays 0.
- R4: With `cfg_interlace`=1, field 0 has `cfg_v_total` lines and field 1 has `cfg_v_total`+1 lines. `field` toggles at the first pixel of every field.
- R5: `active` is 1 exactly when `h_count` < `cfg_h_active` and `v_count` < `cfg_v_active`.
- R6: The horizontal sync is at its active level for `h_count` in [`cfg_hsync_start`, `cfg_hsync_start`+`cfg_hsync_len`) and at the opposite level otherwise. The active level is high when `cfg_hsync_high`=1 and low when it is 0.
- R7: The vertical sync is at its active level for every pixel of the lines with `v_count` in [`cfg_vsync_start`, `cfg_vsync_start`+`cfg_vsync_len`). The active level is high when `cfg_vsync_high`=1 and low when it is 0.
- R8: `blank_or_field` equals the inverse of `active` when `cfg_field_on_blank`=0, and equals `field` when `cfg_field_on_blank`=1.
- R9: `fsync_oe` is 1 in master mode (`cfg_slave`=0) and 0 in slave mode. In master mode `fsync_out` is 1 only at `h_count`=0, `v_count`=0, `field`=0. In slave mode `fsync_out` is 0.
- R10: In slave mode, an accepted rising edge of `fsync_in` puts `h_count`, `v_count` and `field` at 0 after the third rising clock edge that follows the change of `fsync_in`. This takes priority over a field change that falls on the same edge.
- R11: After an accepted edge, further rising edges of `fsync_in` are ignored until the block's own count has passed the last pixel of the frame (field 1 when interlaced). The first edge after reset is accepted.
- R12: In master mode `fsync_in` has no effect on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_total | input | CW | Pixels per line, blanking included |
| cfg_h_active | input | CW | Visible pixels per line |
| cfg_hsync_start | input | CW | Pixel at which horizontal sync begins |
| cfg_hsync_len | input | CW | Horizontal sync length in pixels |
| cfg_v_total | input | CW | Lines per frame (progressive) or in field 0 (interlaced) |
| cfg_v_active | input | CW | Visible lines per frame or field |
| cfg_vsync_start | input | CW | Line at which vertical sync begins |
| cfg_vsync_len | input | CW | Vertical sync length in lines |
| cfg_hsync_high | input | 1 | 1: horizontal sync active high |
| cfg_vsync_high | input | 1 | 1: vertical sync active high |
| cfg_interlace | input | 1 | 1: two fields per frame |
| cfg_slave | input | 1 | 1: frame-sync pin is an input and realigns the raster |
| cfg_field_on_blank | input | 1 | 1: shared output carries the field flag instead of blanking |
| fsync_in | input | 1 | External frame sync, used in slave mode |
| fsync_out | output | 1 | Frame-start pulse driven in master mode |
| fsync_oe | output | 1 | Output enable of the frame-sync pin |
| h_count | output | CW | Pixel position in the line |
| v_count | output | CW | Line position in the frame or field |
| field | output | 1 | Odd/even field flag |
| active | output | 1 | Visible-pixel flag |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| blank_or_field | output | 1 | Blanking flag or field flag, by selection |

## Verification
An external realignment and the block's own field change can fall on the same clock edge. This happens when the realigning edge resolves exactly on the last pixel of field 0. The bench provokes it in interlaced slave mode after a reset. It raises the frame sync three samples before the field 0/1 boundary, because the first edge after reset is accepted. It then expects `field` to read 0 and both counters to read 0, not the field-1 start that free running would give. The bench also places a second edge inside the same frame to check that it is ignored, and a later edge after the frame end to check that it is honored. Every sample is compared against a raster computed arithmetically from the number of cycles since the last alignment.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic {
        RT_MASTER = 1'b0,
        RT_SLAVE  = 1'b1
    } rt_mode_e;

    typedef struct packed {
        logic h_vis;
        logic v_vis;
        logic hs_on;
        logic vs_on;
    } rt_win_t;

    function automatic logic rt_in_win(input int unsigned pos,
                                       input int unsigned first,
                                       input int unsigned len);
        return (pos >= first) && (pos < first + len);
    endfunction

    function automatic logic rt_level(input logic on, input logic act_high);
        return act_high ? on : ~on;
    endfunction

endpackage

// File: rtl/raster_fsync_det.sv
module raster_fsync_det (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fsync_in,
    input  logic frame_end,
    output logic resync
);
    logic s1_q, s2_q, s3_q;
    logic armed_q;
    logic rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= fsync_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise   = s2_q & ~s3_q;
    assign resync = en & rise & (armed_q | frame_end);

    always_ff @(posedge clk) begin
        if (rst)            armed_q <= 1'b1;
        else if (resync)    armed_q <= 1'b0;
        else if (frame_end) armed_q <= 1'b1;
    end

    AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
        resync |=> !armed_q); // R11
    AST_REARM_AT_END: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !resync) |=> armed_q); // R11

endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] h_total,
    input  logic [CW-1:0] v_total,
    input  logic          interlace,
    input  logic          resync,
    output logic [CW-1:0] h_q,
    output logic [CW-1:0] v_q,
    output logic          field_q,
    output logic          frame_end
);
    localparam int unsigned XW = CW + 1;

    logic [XW-1:0] h_next_x, v_next_x, v_len_x;
    logic          h_last, v_last;

    assign h_next_x  = {1'b0, h_q} + XW'(1);
    assign v_next_x  = {1'b0, v_q} + XW'(1);
    assign v_len_x   = {1'b0, v_total} + XW'(interlace & field_q);
    assign h_last    = h_next_x >= {1'b0, h_total};
    assign v_last    = v_next_x >= v_len_x;
    assign frame_end = h_last & v_last & (~interlace | field_q);

    always_ff @(posedge clk) begin
        if (rst || resync) begin
            h_q     <= '0;
            v_q     <= '0;
            field_q <= 1'b0;
        end else if (h_last) begin
            h_q <= '0;
            if (v_last) begin
                v_q     <= '0;
                field_q <= interlace ? ~field_q : 1'b0;
            end else begin
                v_q <= v_next_x[CW-1:0];
            end
        end else begin
            h_q <= h_next_x[CW-1:0];
        end
    end

    AST_RESYNC_ZERO: assert property (@(posedge clk) disable iff (rst)
        resync |=> (h_q == '0) && (v_q == '0) && !field_q); // R10
    AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!resync && h_last) |=> (h_q == '0)); // R2
    AST_H_STEP: assert property (@(posedge clk) disable iff (rst)
        (!resync && !h_last) |=> (h_q == $past(h_q) + 1'b1)); // R2
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!resync && !(h_last && v_last)) |=> $stable(field_q)); // R4
    AST_PROG_FIELD: assert property (@(posedge clk) disable iff (rst)
        (!interlace && !field_q) |=> !field_q); // R3

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic [CW-1:0] h,
    input  logic [CW-1:0] v,
    input  logic          fld,
    input  logic [CW-1:0] h_active,
    input  logic [CW-1:0] hs_start,
    input  logic [CW-1:0] hs_len,
    input  logic [CW-1:0] v_active,
    input  logic [CW-1:0] vs_start,
    input  logic [CW-1:0] vs_len,
    input  logic          hs_high,
    input  logic          vs_high,
    input  logic          field_sel,
    output logic          active,
    output logic          hsync,
    output logic          vsync,
    output logic          blank_or_field,
    output logic          frame_start
);
    rt_win_t win;

    always_comb begin
        win.h_vis = h < h_active;
        win.v_vis = v < v_active;
        win.hs_on = rt_in_win(32'(h), 32'(hs_start), 32'(hs_len));
        win.vs_on = rt_in_win(32'(v), 32'(vs_start), 32'(vs_len));
    end

    assign active         = win.h_vis & win.v_vis;
    assign hsync          = rt_level(win.hs_on, hs_high);
    assign vsync          = rt_level(win.vs_on, vs_high);
    assign blank_or_field = field_sel ? fld : ~active;
    assign frame_start    = (h == '0) && (v == '0) && !fld;

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_h_total,
    input  logic [CW-1:0] cfg_h_active,
    input  logic [CW-1:0] cfg_hsync_start,
    input  logic [CW-1:0] cfg_hsync_len,
    input  logic [CW-1:0] cfg_v_total,
    input  logic [CW-1:0] cfg_v_active,
    input  logic [CW-1:0] cfg_vsync_start,
    input  logic [CW-1:0] cfg_vsync_len,
    input  logic          cfg_hsync_high,
    input  logic          cfg_vsync_high,
    input  logic          cfg_interlace,
    input  logic          cfg_slave,
    input  logic          cfg_field_on_blank,
    input  logic          fsync_in,
    output logic          fsync_out,
    output logic          fsync_oe,
    output logic [CW-1:0] h_count,
    output logic [CW-1:0] v_count,
    output logic          field,
    output logic          active,
    output logic          hsync,
    output logic          vsync,
    output logic          blank_or_field
);
    rt_mode_e mode;
    logic     resync, frame_end, frame_start;

    assign mode = rt_mode_e'(cfg_slave);

    raster_fsync_det u_fsync (
        .clk       (clk),
        .rst       (rst),
        .en        (mode == RT_SLAVE),
        .fsync_in  (fsync_in),
        .frame_end (frame_end),
        .resync    (resync)
    );

    raster_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .h_total   (cfg_h_total),
        .v_total   (cfg_v_total),
        .interlace (cfg_interlace),
        .resync    (resync),
        .h_q       (h_count),
        .v_q       (v_count),
        .field_q   (field),
        .frame_end (frame_end)
    );

    raster_decode #(.CW(CW)) u_dec (
        .h              (h_count),
        .v              (v_count),
        .fld            (field),
        .h_active       (cfg_h_active),
        .hs_start       (cfg_hsync_start),
        .hs_len         (cfg_hsync_len),
        .v_active       (cfg_v_active),
        .vs_start       (cfg_vsync_start),
        .vs_len         (cfg_vsync_len),
        .hs_high        (cfg_hsync_high),
        .vs_high        (cfg_vsync_high),
        .field_sel      (cfg_field_on_blank),
        .active         (active),
        .hsync          (hsync),
        .vsync          (vsync),
        .blank_or_field (blank_or_field),
        .frame_start    (frame_start)
    );

    assign fsync_oe  = (mode == RT_MASTER);
    assign fsync_out = fsync_oe & frame_start;

    AST_OE_MODE: assert property (@(posedge clk) disable iff (rst)
        fsync_out |-> fsync_oe); // R9
    AST_MASTER_FREE: assert property (@(posedge clk) disable iff (rst)
        (mode == RT_MASTER) |-> !resync); // R12

endmodule

// File: tb/test_raster_timer.sv
module test_raster_timer;
    localparam int CW  = 12;
    localparam int HT  = 10;
    localparam int HA  = 6;
    localparam int HSS = 7;
    localparam int HSL = 2;
    localparam int VT  = 6;
    localparam int VA  = 4;
    localparam int VSS = 4;
    localparam int VSL = 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, fsync_in, fsync_out, fsync_oe;
    logic hs_high, vs_high, interlace, slave, field_sel;
    logic [CW-1:0] h_count, v_count;
    logic field, active, hsync, vsync, blank_or_field;

    raster_timer #(.CW(CW)) i_raster_timer (
        .clk(clk), .rst(rst),
        .cfg_h_total(CW'(HT)), .cfg_h_active(CW'(HA)),
        .cfg_hsync_start(CW'(HSS)), .cfg_hsync_len(CW'(HSL)),
        .cfg_v_total(CW'(VT)), .cfg_v_active(CW'(VA)),
        .cfg_vsync_start(CW'(VSS)), .cfg_vsync_len(CW'(VSL)),
        .cfg_hsync_high(hs_high), .cfg_vsync_high(vs_high),
        .cfg_interlace(interlace), .cfg_slave(slave),
        .cfg_field_on_blank(field_sel), .fsync_in(fsync_in),
        .fsync_out(fsync_out), .fsync_oe(fsync_oe),
        .h_count(h_count), .v_count(v_count), .field(field),
        .active(active), .hsync(hsync), .vsync(vsync),
        .blank_or_field(blank_or_field)
    );

    int checks = 0;
    int errors = 0;
    int n = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (n=%0d)", req, act, exp, n);
        end
    endtask

    task automatic check_all();
        int per, lines, eh, ev, ef, ea, ehs, evs;
        per   = interlace ? 2 * VT + 1 : VT;
        lines = (n / HT) % per;
        eh    = n % HT;
        if (lines < VT) begin ev = lines; ef = 0; end
        else begin ev = lines - VT; ef = 1; end
        ea  = (eh < HA && ev < VA) ? 1 : 0;
        ehs = (eh >= HSS && eh < HSS + HSL) ? int'(hs_high) : int'(!hs_high);
        evs = (ev >= VSS && ev < VSS + VSL) ? int'(vs_high) : int'(!vs_high);
        chk("R2 h_count", int'(h_count), eh);
        chk(interlace ? "R4 v_count" : "R3 v_count", int'(v_count), ev);
        chk(interlace ? "R4 field" : "R3 field", int'(field), ef);
        chk("R5 active", int'(active), ea);
        chk("R6 hsync", int'(hsync), ehs);
        chk("R7 vsync", int'(vsync), evs);
        chk("R8 blank_or_field", int'(blank_or_field), field_sel ? ef : 1 - ea);
        chk("R9 fsync_oe", int'(fsync_oe), slave ? 0 : 1);
        chk("R9 fsync_out", int'(fsync_out),
            (!slave && eh == 0 && ev == 0 && ef == 0) ? 1 : 0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fsync_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        chk("R1 h_count reset", int'(h_count), 0);
        chk("R1 v_count reset", int'(v_count), 0);
        chk("R1 field reset", int'(field), 0);
        check_all();
    endtask

    task automatic realign(input string req);
        fsync_in = 1'b1;
        step(); check_all();
        step(); check_all();
        step(); n = 0;
        chk({req, " h realigned"}, int'(h_count), 0);
        chk({req, " v realigned"}, int'(v_count), 0);
        chk({req, " field realigned"}, int'(field), 0);
        check_all();
        step(); check_all();
        fsync_in = 1'b0;
    endtask

    task automatic run_to(input int target);
        while (n < target) begin
            step();
            check_all();
        end
    endtask

    initial begin
        #(4 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; fsync_in = 1'b0;
        hs_high = 1'b1; vs_high = 1'b1; interlace = 1'b0; slave = 1'b0; field_sel = 1'b0;

        // master progressive, active-high syncs, blanking on shared pin; R12: fsync_in toggles
        do_reset();
        for (int i = 0; i < 2 * HT * VT + 5; i++) begin
            fsync_in = ~fsync_in;
            step();
            check_all();
        end

        // master interlaced, active-low syncs, field on shared pin (R4, R6, R7, R8)
        interlace = 1'b1; hs_high = 1'b0; vs_high = 1'b0; field_sel = 1'b1;
        do_reset();
        for (int i = 0; i < 2 * HT * (2 * VT + 1) + 5; i++) begin
            step();
            check_all();
        end

        // slave progressive: first edge accepted (R10), in-frame edge ignored, later edge honored (R11)
        interlace = 1'b0; hs_high = 1'b1; vs_high = 1'b0; field_sel = 1'b0; slave = 1'b1;
        do_reset();
        run_to(23);
        realign("R10");
        run_to(15);
        fsync_in = 1'b1;
        run_to(19);
        fsync_in = 1'b0;
        run_to(30);
        chk("R11 in-frame edge ignored h", int'(h_count), 0);
        chk("R11 in-frame edge ignored v", int'(v_count), 3);
        run_to(70);
        realign("R11");
        run_to(40);

        // slave interlaced: realign on the last pixel of field 0 beats the field change (R10)
        interlace = 1'b1; field_sel = 1'b1;
        do_reset();
        run_to(57);
        realign("R10");
        run_to(2 * HT * (2 * VT + 1) + 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule